// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block gathers condition signals from several sources into a register of read-only, sticky status bits. Five sources are covered by default: the left and right auto-mute conditions of a playback channel, clock faults on two serial audio ports, and positive full-scale clipping in the converter path. Each source has a 2-bit trigger mode that selects which change of its condition records an event. Once a bit is set it stays set until software reads the register. A read returns the collected bits and clears them.

A per-source mask bit decides whether a recorded bit may pull the shared active-low interrupt line. A masked source still records its events, so software can poll it. The status register does not show the live clipping level; that level is available elsewhere on the chip. A single-cycle read strobe and a read data port stand in for the host bus.

Top module: `sis_irq_status`

## Requirements
- R1: While reset is asserted and right after it, every status bit reads 0 and the interrupt output `irq_n_o` is 1 (inactive).
- R2: With mode 2'b00 (bits [2i+1:2i] of `mode_i` for source i), a 0-to-1 change of `cond_i[i]` sets status bit i. The bit is visible on `rd_data_o[i]` one clock after the first cycle in which the condition reads 1.
- R3: With mode 2'b01, a 1-to-0 change of `cond_i[i]` sets status bit i, and a 0-to-1 change does not.
- R4: With mode 2'b10, either change of `cond_i[i]` sets status bit i.
- R5: With mode 2'b11, status bit i is set in every cycle in which `cond_i[i]` is 1, so a read made while the condition is still high leaves the bit set.
- R6: In edge modes (00, 01, 10) a bit stays set without a read. A condition that is held steady does not set the bit again after a read has cleared it.
- R7: In the cycle of a read, `rd_data_o` shows the collected bits. On the next clock, every bit without a new event in the read cycle is cleared.
- R8: An event detected in the same cycle as a read sets its bit after the clear, so the event is not lost.
- R9: `irq_n_o` is 0 exactly when some status bit i is 1 while `mask_i[i]` is 0. A change of the mask takes effect without waiting for a clock.
- R10: A masked source (`mask_i[i]` = 1) still records its events in status bit i, while it leaves `irq_n_o` unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cond_i | input | NUM_SRC | Condition level of each source |
| mode_i | input | 2*NUM_SRC | Trigger mode per source: 00 rise, 01 fall, 10 both edges, 11 level |
| mask_i | input | NUM_SRC | 1 keeps a source from driving the interrupt line |
| rd_stb_i | input | 1 | Single-cycle status read strobe |
| rd_data_o | output | NUM_SRC | Sticky status bits |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
A read can fall in the same cycle as a freshly detected event. Only the bit of that event must survive the clear, while the other collected bits drop. The bench provokes this case in two ways. In one, it raises a condition in the exact cycle it pulses the read strobe, with other bits already set. In the other, it runs a randomized stretch of reads and condition changes. The result is judged by comparing the register and the interrupt line, in every cycle, against a behavioural model that clears first and then records the event.

// File: rtl/sis_pkg.sv
package sis_pkg;

  typedef enum logic [1:0] {
    TRIG_RISE  = 2'b00,
    TRIG_FALL  = 2'b01,
    TRIG_BOTH  = 2'b10,
    TRIG_LEVEL = 2'b11
  } trig_mode_e;

  // Decide whether a source records an event this cycle
  function automatic logic trig_fire(input trig_mode_e mode,
                                     input logic now_lvl,
                                     input logic was_lvl);
    logic fire;
    case (mode)
      TRIG_RISE:  fire = now_lvl & ~was_lvl;
      TRIG_FALL:  fire = ~now_lvl & was_lvl;
      TRIG_BOTH:  fire = now_lvl ^ was_lvl;
      default:    fire = now_lvl;
    endcase
    return fire;
  endfunction

  // Next value of a sticky bit: the read clears it first, then the event sets it
  function automatic logic sticky_next(input logic cur,
                                       input logic rd,
                                       input logic ev);
    return (cur & ~rd) | ev;
  endfunction

endpackage

// File: rtl/sis_edge_unit.sv
module sis_edge_unit
  import sis_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cond,
  input  logic [1:0] mode,
  output logic       fire
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cond;
  end

  always_comb begin
    fire = trig_fire(trig_mode_e'(mode), cond, prev_q);
  end

endmodule

// File: rtl/sis_sticky_bank.sv
module sis_sticky_bank
  import sis_pkg::*;
#(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_stb,
  input  logic [WIDTH-1:0] ev,
  output logic [WIDTH-1:0] status
);

  logic [WIDTH-1:0] status_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q[g] <= 1'b0;
      else        status_q[g] <= sticky_next(status_q[g], rd_stb, ev[g]);
    end
  end

  assign status = status_q;

endmodule

// File: rtl/sis_irq_merge.sv
module sis_irq_merge #(
  parameter int unsigned WIDTH = 5
) (
  input  logic [WIDTH-1:0] status,
  input  logic [WIDTH-1:0] mask,
  output logic             irq_n
);

  logic [WIDTH-1:0] live;

  always_comb begin
    live  = status & ~mask;
    irq_n = ~(|live);
  end

endmodule

// File: rtl/sis_irq_status.sv
module sis_irq_status
  import sis_pkg::*;
#(
  parameter int unsigned NUM_SRC = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SRC-1:0]     cond_i,
  input  logic [2*NUM_SRC-1:0]   mode_i,
  input  logic [NUM_SRC-1:0]     mask_i,
  input  logic                   rd_stb_i,
  output logic [NUM_SRC-1:0]     rd_data_o,
  output logic                   irq_n_o
);

  localparam int unsigned MODE_W = 2;

  // Events detected this cycle, one per source
  logic [NUM_SRC-1:0] ev_w;
  logic [NUM_SRC-1:0] status_w;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    sis_edge_unit u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .cond  (cond_i[s]),
      .mode  (mode_i[MODE_W*s +: MODE_W]),
      .fire  (ev_w[s])
    );
  end

  sis_sticky_bank #(.WIDTH(NUM_SRC)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_stb (rd_stb_i),
    .ev     (ev_w),
    .status (status_w)
  );

  sis_irq_merge #(.WIDTH(NUM_SRC)) u_merge (
    .status (status_w),
    .mask   (mask_i),
    .irq_n  (irq_n_o)
  );

  assign rd_data_o = status_w;

endmodule

// File: rtl/sis_irq_status_chk.sv
module sis_irq_status_chk #(
  parameter int unsigned NUM_SRC = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_stb_i,
  input logic [NUM_SRC-1:0] mask_i,
  input logic [NUM_SRC-1:0] ev_w,
  input logic [NUM_SRC-1:0] rd_data_o,
  input logic               irq_n_o
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (irq_n_o && rd_data_o == '0));

  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> ((rd_data_o & $past(rd_data_o)) == $past(rd_data_o)));

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && ev_w == '0) |=> (rd_data_o == '0));

  // R8
  event_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_w != '0) |=> ((rd_data_o & $past(ev_w)) == $past(ev_w)));

  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n_o == ((rd_data_o & ~mask_i) == '0)));

  // R10
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data_o & ~mask_i) == '0) |-> irq_n_o);

endmodule

bind sis_irq_status sis_irq_status_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_stb_i  (rd_stb_i),
  .mask_i    (mask_i),
  .ev_w      (ev_w),
  .rd_data_o (rd_data_o),
  .irq_n_o   (irq_n_o)
);

// File: tb/sis_irq_status_test.sv
module sis_irq_status_test;

  localparam int CLK_PERIOD = 10;
  localparam int N = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   cond_i = '0;
  logic [2*N-1:0] mode_i = '0;
  logic [N-1:0]   mask_i = '0;
  logic           rd_stb_i = 1'b0;
  logic [N-1:0]   rd_data_o;
  logic           irq_n_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference state
  int prev_m [N];
  int stat_m [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  sis_irq_status #(.NUM_SRC(N)) uut (
    .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .mode_i(mode_i),
    .mask_i(mask_i), .rd_stb_i(rd_stb_i), .rd_data_o(rd_data_o), .irq_n_o(irq_n_o)
  );

  function automatic int exp_status();
    int v = 0;
    for (int i = 0; i < N; i++) if (stat_m[i] != 0) v += (1 << i);
    return v;
  endfunction

  function automatic int exp_irq_n();
    for (int i = 0; i < N; i++)
      if (stat_m[i] != 0 && mask_i[i] == 1'b0) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      int md, c, hit;
      if (!rst_n) begin
        prev_m[i] = 0; stat_m[i] = 0;
      end else begin
        md = int'(mode_i[2*i +: 2]);
        c  = int'(cond_i[i]);
        if (md == 0)      hit = (c == 1 && prev_m[i] == 0) ? 1 : 0;
        else if (md == 1) hit = (c == 0 && prev_m[i] == 1) ? 1 : 0;
        else if (md == 2) hit = (c != prev_m[i]) ? 1 : 0;
        else              hit = c;
        if (rd_stb_i) stat_m[i] = 0;
        if (hit == 1) stat_m[i] = 1;
        prev_m[i] = c;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, int'(rd_data_o), exp_status());
      check(cur_req, int'(irq_n_o), exp_irq_n());
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic set_mode(input int src, input logic [1:0] m);
    mode_i[2*src +: 2] = m;
  endtask

  task automatic do_read(input int exp_val);
    rd_stb_i = 1'b1;
    #1 check("R7", int'(rd_data_o), exp_val);
    tick();
    rd_stb_i = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    // R1 reset state
    check("R1", int'(rd_data_o), 0);
    check("R1", int'(irq_n_o), 1);
    rst_n = 1'b1;
    tick();
    check("R1", int'(rd_data_o), 0);

    // R2 rising edge on source 0
    cur_req = "R2";
    cond_i[0] = 1'b1; tick();
    check("R2", int'(rd_data_o), 5'b00001);
    check("R9", int'(irq_n_o), 0);
    tick();
    // R6 held level, then read clears and no re-set
    cur_req = "R6";
    do_read(5'b00001);
    check("R7", int'(rd_data_o), 0);
    tick(); tick();
    check("R6", int'(rd_data_o), 0);
    cond_i[0] = 1'b0; tick();
    check("R2", int'(rd_data_o), 0);

    // R3 falling edge on source 1
    cur_req = "R3";
    set_mode(1, 2'b01);
    cond_i[1] = 1'b1; tick();
    check("R3", int'(rd_data_o), 0);
    cond_i[1] = 1'b0; tick();
    check("R3", int'(rd_data_o), 5'b00010);
    do_read(5'b00010);

    // R4 both edges on source 2
    cur_req = "R4";
    set_mode(2, 2'b10);
    cond_i[2] = 1'b1; tick();
    check("R4", int'(rd_data_o), 5'b00100);
    do_read(5'b00100);
    check("R4", int'(rd_data_o), 0);
    cond_i[2] = 1'b0; tick();
    check("R4", int'(rd_data_o), 5'b00100);
    do_read(5'b00100);

    // R5 level on source 3 survives a read while high
    cur_req = "R5";
    set_mode(3, 2'b11);
    cond_i[3] = 1'b1; tick();
    check("R5", int'(rd_data_o), 5'b01000);
    do_read(5'b01000);
    check("R5", int'(rd_data_o), 5'b01000);
    cond_i[3] = 1'b0; tick();
    do_read(5'b01000);
    check("R5", int'(rd_data_o), 0);

    // R8 event in the read cycle, with another bit already set
    cur_req = "R8";
    cond_i[0] = 1'b1; tick();
    cond_i[0] = 1'b0;
    check("R8", int'(rd_data_o), 5'b00001);
    cond_i[4] = 1'b1;
    do_read(5'b00001);
    check("R8", int'(rd_data_o), 5'b10000);
    cond_i[4] = 1'b0;
    do_read(5'b10000);

    // R10 masked source records; R9 unmask acts at once
    cur_req = "R10";
    mask_i[4] = 1'b1;
    cond_i[4] = 1'b1; tick();
    check("R10", int'(rd_data_o), 5'b10000);
    check("R10", int'(irq_n_o), 1);
    mask_i[4] = 1'b0; #1;
    check("R9", int'(irq_n_o), 0);
    cond_i[4] = 1'b0;
    do_read(5'b10000);
    check("R9", int'(irq_n_o), 1);

    // randomized stretch checked against the model every cycle
    cur_req = "R9";
    for (int k = 0; k < 400; k++) begin
      cond_i   = N'($urandom);
      mask_i   = N'($urandom);
      rd_stb_i = ($urandom % 4) == 0;
      if (k % 50 == 0) mode_i = (2*N)'($urandom);
      tick();
    end
    rd_stb_i = 1'b0;
    tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule